// File: doc/BRIEF.md
# Programmable Clock Divider with Stop

This block builds a slower clock-enable stream from one of several parent tick streams. All logic runs on one system clock. Each parent arrives as a one-cycle tick qualifier. The block picks one parent and divides its ticks by a ratio from 1 to 64. It gives out a one-cycle pulse that closes each output period, and a level that is high for the first half of each period. It can be halted and restarted without leaving a short or broken period behind.

One 32-bit control word drives the block through a plain write port and is read back in full. Its bits 5:0 hold the divisor field, and the ratio is that field plus one. Bit 8 is the halt bit. The source index sits at a position fixed by the build-time parent count. With four parents it is bits 7:6. With eight parents it is bits 14:12. With one parent there is no index field. A halt request together with a zero divisor field stores 0x3F instead, so the field is never zero while halted. A change to the ratio or to the source waits for the end of the period that is running.

Top module: `clkdiv_stop`

## Requirements
- R1: After reset, rd_data reads 0x0000_0100 (divisor field 0, halt bit 8 set), running is 0, and neither div_tick nor div_level is ever high.
- R2: While running with divisor field F, div_tick pulses once every F+1 ticks of the selected parent. The pulse comes in the same cycle as the last tick of the period.
- R3: The source index picks which src_tick bit is counted: bits 14:12 when N_SRC is 8, bits 7:6 when N_SRC is 4. Ticks on the parents that are not selected have no effect.
- R4: For a ratio r of 2 or more, div_level is high for the first floor(r/2) selected ticks of each period. For r = 1, div_level is the selected tick itself, so it is high for one tick per period.
- R5: running equals the inverse of the stored halt bit, and it changes in the cycle after the write.
- R6: A write with bit 8 set and bits 5:0 zero stores 0x3F in the divisor field. A halt write with a nonzero field stores that field unchanged.
- R7: Once halted, the block ends the current period. After that, div_tick and div_level stay low.
- R8: A divisor written while halted leaves the block halted and quiet. After the halt bit is cleared, the block starts a fresh full period with the new ratio.
- R9: Bits outside the divisor field, the halt bit and the source field read back as zero. With N_SRC = 1 the block always counts src_tick[0], whatever is written in bits 7:6 or 14:12.
- R10: A ratio or source change made in the middle of a period only takes effect at the next period boundary. Every period has the old ratio or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Stored control word |
| src_tick | input | N_SRC | Parent tick streams, one bit each |
| div_tick | output | 1 | One-cycle pulse on the last tick of each output period |
| div_level | output | 1 | Divided level, high during the first half of each period |
| running | output | 1 | High when the halt bit is clear |

## Verification
The hardest case to reach from the ports is a control write that lands inside a period, or exactly on a period boundary. Either way, the next periods must have one ratio, never a mix of two. To reach it, the bench drives every parent with independent random ticks and writes new settings at random points in a period. It skips the two periods that can straddle the write and then measures several full periods in selected ticks. Halting is reached from many period phases the same way, and the block must then go silent within one period.

// File: rtl/clkdiv_stop.sv
module clkdiv_stop #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [N_SRC-1:0] src_tick,
  output logic             div_tick,
  output logic             div_level,
  output logic             running
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int SP = (N_SRC == 8) ? 12 : 6;
  localparam int HALT_BIT = 8;

  logic [5:0]    div_q, act_div, cnt;
  logic          halt_q, active;
  logic [SW-1:0] sel_q, act_sel;
  logic          tick, last;
  logic [6:0]    half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      halt_q <= 1'b1;
      sel_q  <= '0;
    end else if (wr_en) begin
      halt_q <= wr_data[HALT_BIT];
      div_q  <= (wr_data[HALT_BIT] && wr_data[5:0] == 6'd0) ? 6'h3f : wr_data[5:0];
      sel_q  <= (N_SRC > 1) ? wr_data[SP +: SW] : '0;
    end
  end

  generate
    if (N_SRC > 1) begin : g_sel
      assign rd_data = ({26'd0, div_q} | ({31'd0, halt_q} << HALT_BIT)
                        | ({{(32-SW){1'b0}}, sel_q} << SP));
      assign tick = src_tick[act_sel];
    end else begin : g_one
      assign rd_data = {26'd0, div_q} | ({31'd0, halt_q} << HALT_BIT);
      assign tick = src_tick[0];
    end
  endgenerate

  assign last = active && tick && (cnt == act_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      act_div <= '0;
      act_sel <= '0;
    end else if (!active) begin
      if (!halt_q) begin
        active  <= 1'b1;
        cnt     <= '0;
        act_div <= div_q;
        act_sel <= sel_q;
      end
    end else if (last) begin
      cnt <= '0;
      if (halt_q) active <= 1'b0;
      else begin
        act_div <= div_q;
        act_sel <= sel_q;
      end
    end else if (tick) begin
      cnt <= cnt + 6'd1;
    end
  end

  assign half      = ({1'b0, act_div} + 7'd1) >> 1;
  assign div_tick  = last;
  assign div_level = active && ((act_div == 6'd0) ? tick : ({1'b0, cnt} < half));
  assign running   = !halt_q;
endmodule

// File: rtl/clkdiv_stop_chk.sv
module clkdiv_stop_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic [N_SRC-1:0] src_tick,
  input logic             div_tick,
  input logic             div_level,
  input logic             running,
  input logic             active,
  input logic [5:0]       act_div
);
  a_r5_running_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> running == !$past(wr_data[8]));

  a_r6_forced_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[8] && wr_data[5:0] == 6'd0) |=> rd_data[5:0] == 6'h3f);

  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!div_tick && !div_level));

  a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> (|src_tick));

  a_r4_unit_ratio_level: assert property (@(posedge clk) disable iff (!rst_n)
    (active && act_div == 6'd0) |-> (div_level == div_tick));

  a_r1_reset_halted: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 32'h100 && !running));
endmodule

bind clkdiv_stop clkdiv_stop_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .src_tick(src_tick), .div_tick(div_tick), .div_level(div_level), .running(running),
  .active(active), .act_div(act_div)
);

// File: tb/clkdiv_stop_bench.sv
module clkdiv_stop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic we8 = 1'b0, we4 = 1'b0, we1 = 1'b0;
  logic [7:0] src = '0;
  logic [31:0] rd8, rd4, rd1;
  logic t8, l8, r8, t4, l4, r4, t1, l1, r1;
  int n_tests = 0, n_fail = 0;
  logic s_t8, s_l8, s_r8, s_t1, s_l1, s_t4, s_l4;
  logic [7:0] s_src;

  always #10 clk = ~clk;

  clkdiv_stop #(.N_SRC(8)) u_clkdiv_stop (.clk(clk), .rst_n(rst_n), .wr_en(we8), .wr_data(wdata),
    .rd_data(rd8), .src_tick(src), .div_tick(t8), .div_level(l8), .running(r8));
  clkdiv_stop #(.N_SRC(4)) u_four (.clk(clk), .rst_n(rst_n), .wr_en(we4), .wr_data(wdata),
    .rd_data(rd4), .src_tick(src[3:0]), .div_tick(t4), .div_level(l4), .running(r4));
  clkdiv_stop #(.N_SRC(1)) u_one (.clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_data(wdata),
    .rd_data(rd1), .src_tick(src[0:0]), .div_tick(t1), .div_level(l1), .running(r1));

  function automatic int exp_high(int r);
    return (r == 1) ? 1 : r / 2;
  endfunction

  function automatic logic [31:0] exp_rd(int n, logic [31:0] d);
    logic [31:0] v;
    v = d & 32'h13f;
    if (d[8] && d[5:0] == 6'd0) v[5:0] = 6'h3f;
    if (n == 8) v |= d & 32'h7000;
    if (n == 4) v |= d & 32'hc0;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    src = 8'($urandom);
    #5;
    s_src = src; s_t8 = t8; s_l8 = l8; s_r8 = r8;
    s_t4 = t4; s_l4 = l4; s_t1 = t1; s_l1 = l1;
  endtask

  task automatic wr(int which, logic [31:0] d);
    wdata = d;
    we8 = (which == 8); we4 = (which == 4); we1 = (which == 1);
    step();
    we8 = 1'b0; we4 = 1'b0; we1 = 1'b0;
  endtask

  task automatic measure(int which, int r, int sel, int nper, string req);
    int cnt = 0, hi = 0, skip = 2, done = 0, bad_p = 0, bad_h = 0, lastp = 0, lasth = 0;
    for (int k = 0; k < 40000 && done < nper; k++) begin
      logic tk, lv, pu;
      step();
      tk = s_src[sel];
      lv = (which == 8) ? s_l8 : (which == 4) ? s_l4 : s_l1;
      pu = (which == 8) ? s_t8 : (which == 4) ? s_t4 : s_t1;
      if (tk) cnt++;
      if (tk && lv) hi++;
      if (pu) begin
        if (skip > 0) skip--;
        else begin
          done++;
          if (cnt != r) begin bad_p++; lastp = cnt; end
          if (hi != exp_high(r)) begin bad_h++; lasth = hi; end
        end
        cnt = 0; hi = 0;
      end
    end
    chk(done == nper, {req, " periods seen"}, done, nper);
    chk(bad_p == 0, {req, " period length"}, lastp, r);
    chk(bad_h == 0, {"R4 high ticks (", req, ")"}, lasth, exp_high(r));
  endtask

  task automatic quiet(string req, int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (s_t8 || s_l8) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd13));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(rd8 == 32'h100, "R1 reset word", rd8, 32'h100);
    chk(s_r8 == 1'b0, "R1 reset running", s_r8, 0);
    quiet("R1 quiet after reset", 60);

    wr(8, 32'h0000_3005);
    step();
    chk(s_r8 == 1'b1, "R5 running after clear", s_r8, 1);
    measure(8, 6, 3, 3, "R2 ratio6 src3");
    wr(8, 32'h0000_0000);
    measure(8, 1, 0, 4, "R2 ratio1 passthrough");
    wr(8, 32'h0000_703f);
    measure(8, 64, 7, 3, "R2 ratio64 src7");
    wr(8, 32'h0000_1001);
    measure(8, 2, 1, 3, "R3 ratio2 src1");

    for (int i = 0; i < 8; i++) begin
      int f, s;
      f = $urandom_range(0, 20);
      s = $urandom_range(0, 7);
      repeat ($urandom_range(0, 9)) step();
      wr(8, 32'(f) | (32'(s) << 12));
      measure(8, f + 1, s, 3, "R10 midperiod change");
    end

    wr(8, 32'h0000_2100);
    step();
    chk(rd8 == 32'h0000_213f, "R6 forced 0x3f", rd8, 32'h213f);
    chk(s_r8 == 1'b0, "R5 running after halt", s_r8, 0);
    repeat (400) step();
    quiet("R7 quiet while halted", 200);

    wr(8, 32'h0000_2105);
    step();
    chk(rd8[5:0] == 6'd5, "R6 nonzero kept", rd8[5:0], 5);
    wr(8, 32'h0000_2102);
    step();
    chk(rd8 == 32'h0000_2102, "R8 word while halted", rd8, 32'h2102);
    chk(s_r8 == 1'b0, "R8 still halted", s_r8, 0);
    quiet("R8 quiet after divisor write", 200);
    wr(8, 32'h0000_2002);
    measure(8, 3, 2, 3, "R8 new ratio after restart");

    wr(8, 32'hffff_ffff);
    step();
    chk(rd8 == exp_rd(8, 32'hffff_ffff), "R9 readback n8", rd8, exp_rd(8, 32'hffff_ffff));
    wr(4, 32'hffff_ffff);
    step();
    chk(rd4 == exp_rd(4, 32'hffff_ffff), "R9 readback n4", rd4, exp_rd(4, 32'hffff_ffff));
    wr(1, 32'hffff_ffff);
    step();
    chk(rd1 == exp_rd(1, 32'hffff_ffff), "R9 readback n1", rd1, exp_rd(1, 32'hffff_ffff));
    wr(4, 32'h0000_0083);
    measure(4, 4, 2, 3, "R3 four parents src2");
    wr(1, 32'h0000_70c3);
    measure(1, 4, 0, 3, "R9 single parent ignores select");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule